// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision binary floating-point operands. Each operand word has three fields: a sign in bit 31, an 8-bit exponent in bits 30:23 biased by 127, and a 23-bit fraction in bits 22:0. A normal operand has an implied leading 1 ahead of its fraction. When the op input is high, the block computes a minus b by inverting the sign of b before the addition.

The datapath works through six steps in order. It splits the operand fields and restores the hidden bits. It right-shifts the significand of the smaller operand so that both exponents match, keeping guard, round and sticky bits. It adds or subtracts the magnitudes. It renormalises the result, shifting left after cancellation or right after a carry. It rounds to nearest with ties to even. Finally it checks the exponent range.

The arithmetic is combinational. One register stage holds the result word and the two flags, so a result appears one clock after its operands are sampled. Subnormals are not supported: subnormal inputs are taken as zero, and results below the normal range are flushed to zero.

Top module: `fp32_addsub`

## Requirements
- R1: For two normal operands with op low, result is the sum rounded to the nearest representable single-precision value, packed as sign bit 31, exponent bits 30:23 with bias 127, and fraction bits 22:0.
- R2: With op high, result equals the sum of a and b with the sign of b (bit 31) inverted.
- R3: When the exponents differ by more than 26, the smaller operand is absorbed and the result equals the larger operand with its effective sign.
- R4: After cancellation the sum is shifted left and the exponent lowered until the leading bit is 1. For example, 0x3F000000 + 0xBEE00000 gives 0x3D800000.
- R5: Rounding is to nearest. An exact tie goes to the value whose fraction LSB (bit 0) is 0.
- R6: When rounding carries out of the 24-bit significand, the significand is shifted right by one and the exponent incremented, for example 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R7: When the rounded exponent reaches 255, result is infinity with the result sign (exponent 0xFF, fraction 0) and overflow is 1. In every other case overflow is 0.
- R8: A NaN operand (exponent 255, fraction non-zero), or two infinities of opposite effective sign, gives result 0x7FC00000 with invalid at 1. In every other case invalid is 0.
- R9: When exactly one operand is infinite and the other is not a NaN, result is that infinity with its effective sign, and both flags are 0.
- R10: A sum that is exactly zero gives +0 (0x00000000).
- R11: An operand with exponent field 0 counts as zero whatever its fraction holds. A rounded result with an exponent of 0 or less becomes a zero carrying the result sign. No output has exponent 0 with a non-zero fraction.
- R12: result, overflow and invalid are registered: they reflect the operands sampled at the previous rising clock edge, and they are all 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects a minus b, 0 selects a plus b |
| result | output | 32 | Registered sum or difference |
| overflow | output | 1 | Registered overflow flag |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
Some properties are checked on every cycle. Overflow always comes with an infinite result and invalid always with the quiet NaN, and the two flags never rise together. A NaN operand raises invalid one cycle later. Equal operands subtracted give +0, and no subnormal pattern reaches the output. Only the bench scenarios can show the numeric value of each result. These include the cancellation example, ties to even, the rounding carry, absorption of a far smaller operand, flushing below the normal range, and a large set of mixed-exponent vectors compared against an integer reference model.

// File: rtl/fp32_addsub.sv
module fp32_addsub #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EW+FW:0]      op_a,
  input  logic [EW+FW:0]      op_b,
  input  logic                op_sub,
  output logic [EW+FW:0]      result,
  output logic                overflow,
  output logic                invalid
);
  localparam int W   = 1 + EW + FW;
  localparam int MW  = FW + 1;
  localparam int GW  = MW + 3;
  localparam int XW  = 2 * MW + 2;
  localparam int LZW = $clog2(GW + 1);
  localparam int DW  = $clog2(XW + 1);
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [W-1:0]  QNAN = {1'b0, EMAX, 1'b1, {(FW-1){1'b0}}};

  // unpack
  wire          sa = op_a[W-1];
  wire          sb = op_b[W-1] ^ op_sub;
  wire [EW-1:0] ea = op_a[W-2:FW];
  wire [EW-1:0] eb = op_b[W-2:FW];
  wire          za = (ea == '0);
  wire          zb = (eb == '0);
  wire          nan_a = (ea == EMAX) && (op_a[FW-1:0] != '0);
  wire          nan_b = (eb == EMAX) && (op_b[FW-1:0] != '0);
  wire          inf_a = (ea == EMAX) && (op_a[FW-1:0] == '0);
  wire          inf_b = (eb == EMAX) && (op_b[FW-1:0] == '0);
  wire          eff_sub = sa ^ sb;

  wire [W-2:0]  ma = za ? '0 : op_a[W-2:0];
  wire [W-2:0]  mb = zb ? '0 : op_b[W-2:0];
  wire          swap = (mb > ma);
  wire          s_big = swap ? sb : sa;
  wire [W-2:0]  m_big = swap ? mb : ma;
  wire [W-2:0]  m_sml = swap ? ma : mb;
  wire [EW-1:0] e_big = m_big[W-2:FW];
  wire [EW-1:0] e_sml = m_sml[W-2:FW];
  wire [MW-1:0] sig_big = {e_big != '0, m_big[FW-1:0]};
  wire [MW-1:0] sig_sml = {e_sml != '0, m_sml[FW-1:0]};

  // align
  wire [EW-1:0] dexp = e_big - e_sml;
  wire [DW-1:0] dcap = (32'(dexp) >= XW) ? DW'(XW) : DW'(dexp);
  wire [XW-1:0] ext  = {sig_sml, {(XW-MW){1'b0}}} >> dcap;
  wire [GW-1:0] al   = {ext[XW-1:XW-MW-2], |ext[XW-MW-3:0]};
  wire [GW-1:0] bl   = {sig_big, 3'b000};

  // add
  wire [GW:0]   sum = eff_sub ? ({1'b0, bl} - {1'b0, al}) : ({1'b0, bl} + {1'b0, al});

  // normalise
  logic [LZW-1:0] lz;
  always_comb begin
    lz = LZW'(GW);
    for (int i = 0; i < GW; i++)
      if (sum[i]) lz = LZW'(GW - 1 - i);
  end

  logic [GW-1:0]          nrm;
  logic signed [EW+1:0]   en;
  always_comb begin
    if (sum[GW]) begin
      nrm = {sum[GW:2], sum[1] | sum[0]};
      en  = $signed({2'b00, e_big}) + 1;
    end else begin
      nrm = sum[GW-1:0] << lz;
      en  = $signed({2'b00, e_big}) - $signed({{(EW+2-LZW){1'b0}}, lz});
    end
  end

  // round to nearest even
  wire          rinc = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
  wire [MW:0]   rnd  = {1'b0, nrm[GW-1:3]} + (MW+1)'(rinc);
  wire signed [EW+1:0] er = en + $signed({{(EW+1){1'b0}}, rnd[MW]});
  wire [FW-1:0] fr = rnd[MW] ? rnd[FW:1] : rnd[FW-1:0];

  // range check and pack
  logic [W-1:0] res_d;
  logic         ovf_d, inv_d;
  always_comb begin
    ovf_d = 1'b0;
    inv_d = 1'b0;
    if (nan_a || nan_b || (inf_a && inf_b && eff_sub)) begin
      res_d = QNAN;
      inv_d = 1'b1;
    end else if (inf_a)
      res_d = {sa, EMAX, {FW{1'b0}}};
    else if (inf_b)
      res_d = {sb, EMAX, {FW{1'b0}}};
    else if (sum == '0)
      res_d = '0;
    else if (er >= $signed({2'b00, EMAX})) begin
      res_d = {s_big, EMAX, {FW{1'b0}}};
      ovf_d = 1'b1;
    end else if (er <= 0)
      res_d = {s_big, {(W-1){1'b0}}};
    else
      res_d = {s_big, er[EW-1:0], fr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      overflow <= 1'b0;
      invalid  <= 1'b0;
    end else begin
      result   <= res_d;
      overflow <= ovf_d;
      invalid  <= inv_d;
    end
  end
endmodule

// File: rtl/fp32_addsub_chk.sv
module fp32_addsub_chk #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input logic           clk,
  input logic           rst_n,
  input logic [EW+FW:0] op_a,
  input logic [EW+FW:0] op_b,
  input logic           op_sub,
  input logic [EW+FW:0] result,
  input logic           overflow,
  input logic           invalid
);
  localparam int W = 1 + EW + FW;
  localparam logic [EW-1:0] EMAX = '1;

  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result[W-2:0] == {EMAX, {FW{1'b0}}}));

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && invalid));

  p_inv_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (result == {1'b0, EMAX, 1'b1, {(FW-1){1'b0}}}));

  p_nan_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_a[W-2:FW] == EMAX) && (op_a[FW-1:0] != '0)) |=> invalid);

  p_cancel_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_a == op_b) && op_sub && (op_a[W-2:FW] != EMAX)) |=> (result == '0));

  p_no_subnormal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (result[W-2:FW] == '0) |-> (result[FW-1:0] == '0));
endmodule

bind fp32_addsub fp32_addsub_chk #(.EW(EW), .FW(FW)) u_chk (.*);

// File: tb/tb_fp32_addsub.sv
module tb_fp32_addsub;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic        op_sub;
  wire  [31:0] result;
  wire         overflow, invalid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  fp32_addsub dut (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
                   .op_sub(op_sub), .result(result), .overflow(overflow),
                   .invalid(invalid));

  localparam logic [33:0] QNAN_X = {2'b10, 32'h7FC00000};

  // integer reference: returns {invalid, overflow, result}
  function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b, logic s);
    logic sa, sb, st;
    int ea, eb, et, d, p, e, sh;
    longint unsigned ma, mb, mt, x, y, t, keep, rem, half;
    sa = a[31]; sb = b[31] ^ s;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return QNAN_X;
    if (ea == 255 && eb == 255 && sa != sb) return QNAN_X;
    if (ea == 255) return {2'b00, sa, 8'hFF, 23'h0};
    if (eb == 255) return {2'b00, sb, 8'hFF, 23'h0};
    if (ea == 0 && eb == 0) return 34'h0;
    if (ea == 0) return {2'b00, sb, b[30:0]};
    if (eb == 0) return {2'b00, sa, a[30:0]};
    ma = 64'(a[22:0]) | (64'd1 << 23);
    mb = 64'(b[22:0]) | (64'd1 << 23);
    if (eb > ea || (eb == ea && mb > ma)) begin
      st = sa; sa = sb; sb = st;
      et = ea; ea = eb; eb = et;
      mt = ma; ma = mb; mb = mt;
    end
    d = ea - eb;
    if (d > 26) return {2'b00, sa, 8'(ea), ma[22:0]};
    x = ma << 30;
    y = (mb << 30) >> d;
    t = (sa == sb) ? x + y : x - y;
    if (t == 0) return 34'h0;
    p = 63;
    while (t[p] == 1'b0) p--;
    sh = p - 23;
    keep = t >> sh;
    rem = t & ((64'd1 << sh) - 1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && keep[0])) keep++;
    e = ea + p - 53;
    if (keep == (64'd1 << 24)) begin keep = keep >> 1; e++; end
    if (e >= 255) return {2'b01, sa, 8'hFF, 23'h0};
    if (e <= 0) return {2'b00, sa, 31'h0};
    return {2'b00, sa, 8'(e), keep[22:0]};
  endfunction

  task automatic check(string tag, logic [33:0] got, logic [33:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got res=%h ovf=%b inv=%b, expected res=%h ovf=%b inv=%b",
               tag, got[31:0], got[32], got[33], exp[31:0], exp[32], exp[33]);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register stage)
  task automatic run(string tag, logic [31:0] a, logic [31:0] b, logic s,
                     logic [33:0] exp);
    op_a = a; op_b = b; op_sub = s;
    @(negedge clk);
    check(tag, {invalid, overflow, result}, exp);
  endtask

  task automatic run_model(string tag, logic [31:0] a, logic [31:0] b, logic s);
    run(tag, a, b, s, model(a, b, s));
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = 32'h3F800000; op_b = 32'h3F800000; op_sub = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset", {invalid, overflow, result}, 34'h0);
    rst_n = 1'b1;

    run("R1 1+1", 32'h3F800000, 32'h3F800000, 1'b0, {2'b00, 32'h40000000});
    run("R1 2.5+0.75", 32'h40200000, 32'h3F400000, 1'b0, {2'b00, 32'h40500000});
    run("R2 3-1", 32'h40400000, 32'h3F800000, 1'b1, {2'b00, 32'h40000000});
    run("R2 1-3", 32'h3F800000, 32'h40400000, 1'b1, {2'b00, 32'hC0000000});
    run("R3 absorb add", 32'h3F800000, 32'h30800000, 1'b0, {2'b00, 32'h3F800000});
    run("R3 absorb sub", 32'h30800000, 32'h3F800000, 1'b1, {2'b00, 32'hBF800000});
    run("R4 cancel", 32'h3F000000, 32'hBEE00000, 1'b0, {2'b00, 32'h3D800000});
    run("R5 tie even down", 32'h3F800000, 32'h33800000, 1'b0, {2'b00, 32'h3F800000});
    run("R5 tie even up", 32'h3F800001, 32'h33800000, 1'b0, {2'b00, 32'h3F800002});
    run("R6 round carry", 32'h3FFFFFFF, 32'h33800000, 1'b0, {2'b00, 32'h40000000});
    run("R7 overflow +", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {2'b01, 32'h7F800000});
    run("R7 overflow -", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, {2'b01, 32'hFF800000});
    run("R7 max no ovf", 32'h7F7FFFFF, 32'h3F800000, 1'b0, {2'b00, 32'h7F7FFFFF});
    run("R8 nan in", 32'h7FC00000, 32'h3F800000, 1'b0, QNAN_X);
    run("R8 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, QNAN_X);
    run("R9 inf pass", 32'h3F800000, 32'h7F800000, 1'b1, {2'b00, 32'hFF800000});
    run("R9 inf+inf", 32'hFF800000, 32'h7F800000, 1'b1, {2'b00, 32'hFF800000});
    run("R10 x-x", 32'h40490FDB, 32'h40490FDB, 1'b1, 34'h0);
    run("R10 -2+2", 32'hC0000000, 32'h40000000, 1'b0, 34'h0);
    run("R11 sub in", 32'h00400000, 32'h3F800000, 1'b0, {2'b00, 32'h3F800000});
    run("R11 flush", 32'h00800000, 32'h00800001, 1'b1, {2'b00, 32'h80000000});

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 2 == 0) b[30:23] = a[30:23] + 8'($urandom_range(0, 4)) - 8'd2;
      if (i % 7 == 0) b[22:0] = a[22:0];
      run_model((i % 2 == 0) ? "R4 rnd near" : "R1 rnd", a, b, 1'($urandom));
    end
    for (int i = 0; i < 500; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      a[30:23] = 8'($urandom_range(240, 254));
      b[30:23] = 8'($urandom_range(240, 254));
      run_model("R7 rnd high", a, b, 1'($urandom));
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected end of run");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule